// File: doc/BRIEF.md
# Banked Shadow Register File

This block is the integer register storage of a 64-bit core: two combinational read ports and one clocked write port over 31 architectural registers, each 64 bits wide. Index 31 is a constant zero source and a discard sink for writes.

Next to the main storage sits an eight-entry shadow bank. While the privileged-mode input is high, a fixed group of architectural indices is steered into that bank instead of the main one: indices 8 to 14 reach shadow slots 0 to 6, and index 25 reaches shadow slot 7. Reads and writes follow the same steering. Privileged code therefore gets scratch registers without saving the interrupted context, and returning to normal mode makes the original values visible again unchanged. The steering decision uses the mode flag of the cycle in which the access happens. Decode, forwarding and the logic that drives the mode flag live outside this block.

Top module: `banked_regfile`

## Requirements
- R1: With privileged mode low, a write of value V to index i (0 to 30) makes both read ports return V for index i from the next cycle on, for every i and on both ports.
- R2: With privileged mode high, indices 8 to 14 access shadow slots 0 to 6 for reads and writes; a value written there is read back in privileged mode, while a read of the same index in normal mode returns the main-bank value.
- R3: With privileged mode high, index 25 accesses shadow slot 7 for reads and writes, and the main-bank entry 25 is left unchanged.
- R4: With privileged mode low, no write changes any shadow slot: a normal-mode write to index 8 to 14 or 25 is not visible through that index in privileged mode.
- R5: Indices outside 8 to 14 and 25 access the main bank in both modes, so a value written in one mode is read back in the other.
- R6: Index 31 reads as zero on both ports in both modes, and a write to index 31 changes no register.
- R7: The bank choice for a write and for each read uses the privileged-mode value present in that same cycle, so the flag may change on every cycle.
- R8: Reads are combinational; a write takes effect at the rising clock edge, so a read of the index being written in the same cycle returns the previous value.
- R9: A synchronous reset clears every main and shadow entry to zero.
- R10: The two read ports are independent: in one cycle one may read a shadow slot while the other reads the main bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| privMode | input | 1 | Privileged-mode flag, steers the shadowed indices |
| rdAddrA | input | 5 | Read index, port A |
| rdAddrB | input | 5 | Read index, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write index |
| wrData | input | 64 | Write value |
| rdDataA | output | 64 | Read value, port A |
| rdDataB | output | 64 | Read value, port B |

## Verification
The hard case is telling the two banks apart through ports that only carry an index: a shadow slot and its main-bank twin answer to the same address. The stimulus first loads the main bank with one pattern in normal mode, then loads the shadowed indices with a different pattern in privileged mode, and then reads every shadowed index in both modes, including cycles where the flag flips between a write and the following read and where the two ports sit in different modes' views within one cycle.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int DATA_W      = 64;
  localparam int ADDR_W      = 5;
  localparam int ARCH_REGS   = 31;
  localparam int SHADOW_REGS = 8;
  localparam int SHD_W       = $clog2(SHADOW_REGS);
  localparam int RUN_BASE    = 8;
  localparam int RUN_LEN     = 7;
  localparam int LONE_REG    = 25;
  localparam int ZERO_REG    = 31;
  localparam int RD_PORTS    = 2;

  // Where one index lands after the mode steering.
  typedef struct packed {
    logic              useShad;
    logic              isZero;
    logic [ADDR_W-1:0] normIdx;
    logic [SHD_W-1:0]  shadIdx;
  } bankSel_t;

  // Strobes from the steering control to the storage.
  typedef struct packed {
    logic     normWe;
    logic     shadWe;
    bankSel_t wrSel;
    bankSel_t rdSelA;
    bankSel_t rdSelB;
  } rfStrobes_t;
endpackage

// File: rtl/brf_remap_ctrl.sv
module brf_remap_ctrl
  import brf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              privMode,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output rfStrobes_t        strobes
);
  localparam int N_PORTS = RD_PORTS + 1;

  logic [ADDR_W-1:0] portAddr [N_PORTS];
  bankSel_t          portSel  [N_PORTS];

  assign portAddr[0] = wrAddr;
  assign portAddr[1] = rdAddrA;
  assign portAddr[2] = rdAddrB;

  // One steering decoder per port, all sharing the current mode flag.
  for (genvar p = 0; p < N_PORTS; p++) begin : g_map
    logic inRun;
    logic isLone;
    assign inRun  = (portAddr[p] >= ADDR_W'(RUN_BASE)) &&
                    (portAddr[p] <  ADDR_W'(RUN_BASE + RUN_LEN));
    assign isLone = (portAddr[p] == ADDR_W'(LONE_REG));
    always_comb begin
      portSel[p].isZero  = (portAddr[p] == ADDR_W'(ZERO_REG));
      portSel[p].useShad = privMode && (inRun || isLone);
      portSel[p].normIdx = portAddr[p];
      if (isLone) portSel[p].shadIdx = SHD_W'(SHADOW_REGS - 1);
      else        portSel[p].shadIdx = SHD_W'(portAddr[p] - ADDR_W'(RUN_BASE));
    end
  end

  always_comb begin
    strobes.wrSel  = portSel[0];
    strobes.rdSelA = portSel[1];
    strobes.rdSelB = portSel[2];
    strobes.shadWe = wrEn && portSel[0].useShad;
    strobes.normWe = wrEn && !portSel[0].useShad && !portSel[0].isZero;
  end

  AST_SHADOW_WRITE_NEEDS_PRIV: assert property (@(posedge clk) disable iff (rst)
    strobes.shadWe |-> privMode); // R4
  AST_ZERO_INDEX_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrAddr == ADDR_W'(ZERO_REG)) |-> !strobes.normWe && !strobes.shadWe); // R6
  AST_LONE_TO_LAST_SLOT: assert property (@(posedge clk) disable iff (rst)
    (privMode && wrEn && wrAddr == ADDR_W'(LONE_REG)) |->
      strobes.shadWe && strobes.wrSel.shadIdx == SHD_W'(SHADOW_REGS - 1)); // R3
  AST_ONE_BANK_PER_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.normWe, strobes.shadWe})); // R2
endmodule

// File: rtl/brf_storage_dp.sv
module brf_storage_dp
  import brf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  rfStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [DATA_W-1:0] normBank [ARCH_REGS];
  logic [DATA_W-1:0] shadBank [SHADOW_REGS];
  logic [ARCH_REGS*DATA_W-1:0]   normFlat;
  logic [SHADOW_REGS*DATA_W-1:0] shadFlat;

  for (genvar i = 0; i < ARCH_REGS; i++) begin : g_norm
    always_ff @(posedge clk) begin
      if (rst) normBank[i] <= '0;
      else if (strobes.normWe && strobes.wrSel.normIdx == ADDR_W'(i))
        normBank[i] <= wrData;
    end
    assign normFlat[i*DATA_W +: DATA_W] = normBank[i];
  end

  for (genvar s = 0; s < SHADOW_REGS; s++) begin : g_shad
    always_ff @(posedge clk) begin
      if (rst) shadBank[s] <= '0;
      else if (strobes.shadWe && strobes.wrSel.shadIdx == SHD_W'(s))
        shadBank[s] <= wrData;
    end
    assign shadFlat[s*DATA_W +: DATA_W] = shadBank[s];
  end

  function automatic logic [DATA_W-1:0] pickWord(bankSel_t sel,
      logic [ARCH_REGS*DATA_W-1:0] nf, logic [SHADOW_REGS*DATA_W-1:0] sf);
    logic [DATA_W-1:0] v;
    v = '0;
    if (sel.useShad) begin
      for (int s = 0; s < SHADOW_REGS; s++)
        if (sel.shadIdx == SHD_W'(s)) v = sf[s*DATA_W +: DATA_W];
    end else if (!sel.isZero) begin
      for (int i = 0; i < ARCH_REGS; i++)
        if (sel.normIdx == ADDR_W'(i)) v = nf[i*DATA_W +: DATA_W];
    end
    return v;
  endfunction

  assign rdDataA = pickWord(strobes.rdSelA, normFlat, shadFlat);
  assign rdDataB = pickWord(strobes.rdSelB, normFlat, shadFlat);

  AST_SHADOW_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    strobes.shadWe |=> shadBank[$past(strobes.wrSel.shadIdx)] == $past(wrData)); // R2
  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !strobes.shadWe |=> $stable(shadFlat)); // R4
  AST_MAIN_HOLDS_ON_SHADOW: assert property (@(posedge clk) disable iff (rst)
    strobes.shadWe |=> $stable(normFlat)); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (normFlat == '0) && (shadFlat == '0)); // R9
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              privMode,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  rfStrobes_t strobes;

  brf_remap_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .privMode (privMode),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .strobes  (strobes)
  );

  brf_storage_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (wrData),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == ADDR_W'(ZERO_REG)) |-> rdDataA == '0); // R6
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == ADDR_W'(ZERO_REG)) |-> rdDataB == '0); // R6
  AST_SAME_INDEX_SAME_VIEW: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == rdAddrB) |-> rdDataA == rdDataB); // R10
endmodule

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        privMode = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] rdDataA, rdDataB;

  always #2.5 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst(rst), .privMode(privMode), .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB));

  typedef struct { logic [63:0] expA; logic [63:0] expB; string tag; } item_t;
  item_t scoreQ[$];
  event  sampleEv;
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  logic [63:0] mainM [31];
  logic [63:0] shadM [8];

  // Reference steering: -1 zero, 0..30 main, 100+k shadow slot k
  function automatic int refMap(int idx, bit priv);
    if (idx == 31) return -1;
    if (priv) begin
      case (idx)
        8, 9, 10, 11, 12, 13, 14: return 100 + idx - 8;
        25: return 107;
        default: return idx;
      endcase
    end
    return idx;
  endfunction

  function automatic logic [63:0] refRead(int idx, bit priv);
    int m = refMap(idx, priv);
    if (m < 0) return 64'h0;
    if (m >= 100) return shadM[m-100];
    return mainM[m];
  endfunction

  // Driver: one access cycle; expected values pushed before the edge
  task automatic cycle(bit priv, bit we, int wa, logic [63:0] wd,
                       int ra, int rb, string tag);
    item_t it;
    int m;
    @(negedge clk);
    privMode = priv; wrEn = we; wrAddr = 5'(wa); wrData = wd;
    rdAddrA = 5'(ra); rdAddrB = 5'(rb);
    it.expA = refRead(ra, priv);
    it.expB = refRead(rb, priv);
    it.tag  = tag;
    #1;
    scoreQ.push_back(it);
    ->sampleEv;
    @(posedge clk);
    if (we) begin
      m = refMap(wa, priv);
      if (m >= 100) shadM[m-100] = wd;
      else if (m >= 0) mainM[m] = wd;
    end
  endtask

  task automatic rd(bit priv, int ra, int rb, string tag);
    cycle(priv, 1'b0, 0, 64'h0, ra, rb, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0;
    @(posedge clk);
    foreach (mainM[i]) mainM[i] = '0;
    foreach (shadM[i]) shadM[i] = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: compares the ports against queued expectations
  initial begin
    item_t it;
    forever begin
      @(sampleEv);
      while (scoreQ.size() > 0) begin
        it = scoreQ.pop_front();
        checks += 2;
        if (rdDataA !== it.expA) begin
          errors++;
          $display("FAIL %s port A: got %h expected %h", it.tag, rdDataA, it.expA);
        end
        if (rdDataB !== it.expB) begin
          errors++;
          $display("FAIL %s port B: got %h expected %h", it.tag, rdDataB, it.expB);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mainM[i]) mainM[i] = 'x;
    foreach (shadM[i]) shadM[i] = 'x;
    doReset();
    // R9: reset state in both views
    for (int i = 0; i < 32; i += 2) rd(1'b0, i, i + 1, "R9 reset main");
    rd(1'b1, 8, 25, "R9 reset shadow");
    rd(1'b1, 14, 11, "R9 reset shadow");

    // R1: fill main bank in normal mode, read every index back
    for (int i = 0; i < 32; i++)
      cycle(1'b0, 1'b1, i, {32'hA5A5_0000 + 32'(i), 32'(i) * 32'h0101_0101}, 0, 0, "R1 fill");
    for (int i = 0; i < 32; i += 2) rd(1'b0, i, 31 - i, "R1 readback");

    // R2 R3: privileged writes to shadowed indices
    for (int i = 8; i <= 14; i++)
      cycle(1'b1, 1'b1, i, 64'h5EAD_0000_0000_0000 | 64'(i), 0, 0, "R2 shadow fill");
    cycle(1'b1, 1'b1, 25, 64'hC0DE_0025_0000_0007, 0, 0, "R3 shadow fill");
    for (int i = 8; i <= 14; i++) rd(1'b1, i, 25, "R2 R3 priv view");
    for (int i = 8; i <= 14; i++) rd(1'b0, i, 25, "R2 R3 normal view");

    // R5: unshadowed indices shared between modes
    cycle(1'b1, 1'b1, 7,  64'h0000_0007_7777_7777, 0, 0, "R5 write");
    cycle(1'b1, 1'b1, 15, 64'h0000_0015_1515_1515, 0, 0, "R5 write");
    cycle(1'b1, 1'b1, 24, 64'h0000_0024_2424_2424, 0, 0, "R5 write");
    cycle(1'b1, 1'b1, 26, 64'h0000_0026_2626_2626, 0, 0, "R5 write");
    rd(1'b0, 7, 15, "R5 shared");
    rd(1'b0, 24, 26, "R5 shared");
    rd(1'b1, 7, 26, "R5 shared");

    // R4: normal-mode writes never reach the shadow slots
    cycle(1'b0, 1'b1, 10, 64'hDEAD_0010_0000_0000, 0, 0, "R4 write");
    cycle(1'b0, 1'b1, 25, 64'hDEAD_0025_0000_0000, 0, 0, "R4 write");
    rd(1'b1, 10, 25, "R4 shadow untouched");
    rd(1'b0, 10, 25, "R4 main updated");

    // R8: same-cycle read of the written index sees the old value
    cycle(1'b0, 1'b1, 3, 64'h1234_5678_9ABC_DEF0, 3, 3, "R8 old value");
    rd(1'b0, 3, 3, "R8 new value");
    cycle(1'b1, 1'b1, 12, 64'hFEED_FACE_0000_0012, 12, 4, "R8 shadow old");
    rd(1'b1, 12, 4, "R8 shadow new");

    // R7: mode flag flips every cycle
    cycle(1'b1, 1'b1, 9, 64'h0909_0909_AAAA_0001, 9, 9, "R7 priv write");
    cycle(1'b0, 1'b1, 9, 64'h0909_0909_BBBB_0002, 9, 9, "R7 normal write");
    cycle(1'b1, 1'b1, 9, 64'h0909_0909_CCCC_0003, 9, 9, "R7 priv write");
    rd(1'b0, 9, 9, "R7 normal read");
    rd(1'b1, 9, 9, "R7 priv read");

    // R10: ports in different banks in one cycle
    rd(1'b1, 13, 20, "R10 mixed");
    rd(1'b1, 20, 25, "R10 mixed");
    rd(1'b1, 8, 8, "R10 same");

    // R6: index 31 is zero and swallows writes
    cycle(1'b0, 1'b1, 31, 64'hFFFF_FFFF_FFFF_FFFF, 31, 30, "R6 write zero");
    cycle(1'b1, 1'b1, 31, 64'hFFFF_FFFF_FFFF_FFFF, 31, 0, "R6 write zero");
    for (int i = 0; i < 32; i += 2) rd(1'b0, i, i + 1, "R6 no side effect");
    for (int i = 0; i < 32; i += 2) rd(1'b1, i, i + 1, "R6 no side effect");

    // R9: reset after everything is filled
    doReset();
    for (int i = 0; i < 32; i += 2) rd(1'b0, i, i + 1, "R9 cleared main");
    for (int i = 0; i < 32; i += 2) rd(1'b1, i, i + 1, "R9 cleared shadow");

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule